// File: doc/BRIEF.md
# DMA Health Counters and Status

This block sits beside a streaming DMA engine and gives host software a view of how the data path is behaving. Four saturating counters record words delivered toward the host, words accepted from the host, cycles in which the outgoing path was held off by a saturated bus, and underrun events in which the host did not provide transmit data in time. Software reads them through a small register port with an address, a read strobe, a write strobe and registered read data.

A status word reports whether the device is healthy. Its healthy value is a multi-bit pattern that is neither all zeros nor all ones. A read that fails on the host side and returns all ones therefore never looks healthy. A fatal error input latches the status into a fault value. Software can zero every counter with a single write. Reading the transmit counter takes a snapshot of the other three, so one pass over the counters gives a coherent set.

Top module: `dma_health_regs`

## Requirements
- R1: Each clock cycle with `ev_tx_word_i` high adds one to the to-host counter. It reads live at byte address 0x08.
- R2: Each cycle with `ev_rx_word_i` high adds one to the from-host counter, independently of the other counters. It is read at 0x0C.
- R3: Each cycle with `ev_stall_i` high adds one to the saturation-stall counter. It is read at 0x10.
- R4: Each cycle with `ev_underrun_i` high adds one to the underrun counter. It is read at 0x14.
- R5: A counter that reaches 2^CNT_W-1 stays there under further events and does not wrap. Its value reads zero-extended to 32 bits.
- R6: A write to 0x00 with data bit 0 set zeroes all counters and all snapshots in that cycle, and events arriving in the same cycle are lost. A write to 0x00 with bit 0 clear changes nothing.
- R7: The status at 0x04 reads 0x000000A5 after reset. Once `fatal_i` has been high for a cycle it reads 0x00000000, and it stays there until reset. A counter clear does not release it.
- R8: Reads of 0x00 and of any address that is not listed, including misaligned ones, return 0x00000000.
- R9: Read data appears on `reg_rdata_o` on the clock edge that samples `reg_rd_i`. It holds until the next read.
- R10: A read of 0x08 copies the from-host, stall and underrun counters into snapshots on the same edge. Reads of 0x0C, 0x10 and 0x14 return these snapshots, not the live values.
- R11: After reset all counters and snapshots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| ev_tx_word_i | input | 1 | One word sent toward the host this cycle |
| ev_rx_word_i | input | 1 | One word received from the host this cycle |
| ev_stall_i | input | 1 | Outgoing path stalled by bus saturation this cycle |
| ev_underrun_i | input | 1 | Host failed to supply transmit data in time |
| fatal_i | input | 1 | Fatal error indication from the data path |

## Verification
The hardest conditions to reach are counter saturation and the cases where the snapshot differs from the live count. At the default width a counter would need billions of events before it saturates. The bench therefore builds the block with an 8-bit counter width and drives several hundred events, which pushes the counters past their limit. Snapshot coherence is tested by letting the live counts move after a read of 0x08 and confirming that the other addresses still return the earlier values. A clear is issued in the same cycle as an event to show that the event is lost.

// File: rtl/dma_health_pkg.sv
package dma_health_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_CNT  = 4;
  localparam int unsigned CNT_STEP = 4;

  localparam logic [7:0] ADDR_CTRL     = 8'h00;
  localparam logic [7:0] ADDR_STATUS   = 8'h04;
  localparam logic [7:0] ADDR_CNT_BASE = 8'h08;

  localparam logic [7:0]        OK_PATTERN = 8'hA5;
  localparam logic [DATA_W-1:0] CLR_MASK   = 32'h0000_0001;

  typedef enum logic [1:0] {
    CNT_TX       = 2'd0,
    CNT_RX       = 2'd1,
    CNT_STALL    = 2'd2,
    CNT_UNDERRUN = 2'd3
  } cnt_idx_e;
endpackage

// File: rtl/dma_sat_counter.sv
module dma_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;  // same-cycle events dropped
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_health_status.sv
module dma_health_status
  import dma_health_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fatal_i,
  output logic [DATA_W-1:0] status_o
);
  logic fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fatal_q <= 1'b0;
    else if (fatal_i) fatal_q <= 1'b1;
  end

  // healthy pattern is neither all-zero nor all-one
  assign status_o = fatal_q ? '0 : DATA_W'(OK_PATTERN);

  a_r7_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_q |=> fatal_q);

  a_r7_fatal_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_i |=> status_o == '0);
endmodule

// File: rtl/dma_health_readout.sv
module dma_health_readout
  import dma_health_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CNT  = NUM_CNT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       rd_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          status_i,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [CNT_W-1:0]  shadow_q [1:N_CNT-1];
  logic [DATA_W-1:0] rd_next;
  logic              snap;
  logic              hit;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    snap    = 1'b0;
    hit     = 1'b0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) begin
      hit = 1'b1;
    end else if (addr_i == ADDR_W'(ADDR_STATUS)) begin
      hit     = 1'b1;
      rd_next = status_i;
    end else begin
      for (int i = 0; i < int'(N_CNT); i++) begin
        if (addr_i == ADDR_W'(ADDR_CNT_BASE) + ADDR_W'(CNT_STEP * i)) begin
          hit = 1'b1;
          if (i == 0) begin
            snap    = 1'b1;
            rd_next = DATA_W'(cnt_i[0]);
          end else begin
            rd_next = DATA_W'(shadow_q[i]);
          end
        end
      end
    end
  end

  for (genvar g = 1; g < int'(N_CNT); g++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            shadow_q[g] <= '0;
      else if (clr_i)         shadow_q[g] <= '0;
      else if (rd_i && snap)  shadow_q[g] <= cnt_i[g];
    end

    a_r10_shadow_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !(rd_i && snap)) |=> $stable(shadow_q[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit) |=> rdata_o == '0);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/dma_health_regs.sv
module dma_health_regs
  import dma_health_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ev_tx_word_i,
  input  logic              ev_rx_word_i,
  input  logic              ev_stall_i,
  input  logic              ev_underrun_i,
  input  logic              fatal_i
);
  logic                          clr;
  logic [NUM_CNT-1:0]            ev;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [DATA_W-1:0]             status;

  assign clr = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CTRL))
               && |(reg_wdata_i & CLR_MASK);

  assign ev[CNT_TX]       = ev_tx_word_i;
  assign ev[CNT_RX]       = ev_rx_word_i;
  assign ev[CNT_STALL]    = ev_stall_i;
  assign ev[CNT_UNDERRUN] = ev_underrun_i;

  for (genvar g = 0; g < int'(NUM_CNT); g++) begin : g_cnt
    dma_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (ev[g]),
      .cnt_o  (cnt[g])
    );
  end

  dma_health_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fatal_i  (fatal_i),
    .status_o (status)
  );

  dma_health_readout #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .N_CNT  (NUM_CNT)
  ) u_readout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .status_i (status),
    .cnt_i    (cnt),
    .rdata_o  (reg_rdata_o)
  );

  a_r6_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt[CNT_RX] == '0 && cnt[CNT_UNDERRUN] == '0));
endmodule

// File: tb/dma_health_regs_tb_top.sv
module dma_health_regs_tb_top;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev_tx = 1'b0, ev_rx = 1'b0, ev_st = 1'b0, ev_un = 1'b0, fatal = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dma_health_regs #(.ADDR_W(8), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_tx_word_i(ev_tx),
    .ev_rx_word_i(ev_rx), .ev_stall_i(ev_st), .ev_underrun_i(ev_un), .fatal_i(fatal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    {ev_tx, ev_rx, ev_st, ev_un, fatal, rd, wr} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // m = {underrun, stall, rx, tx}
  task automatic pulse(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); {ev_un, ev_st, ev_rx, ev_tx} = m;
    end
    @(negedge clk); {ev_un, ev_st, ev_rx, ev_tx} = '0;
  endtask

  task automatic write_ctrl(input logic [31:0] d, input logic [3:0] m);
    @(negedge clk); addr = 8'h00; wdata = d; wr = 1'b1; {ev_un, ev_st, ev_rx, ev_tx} = m;
    @(negedge clk); wr = 1'b0; {ev_un, ev_st, ev_rx, ev_tx} = '0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    read(8'h08, d); check("R11 tx after reset", d, 0);
    read(8'h0C, d); check("R11 rx after reset", d, 0);
    read(8'h14, d); check("R11 underrun after reset", d, 0);
    read(8'h04, d); check("R7 status healthy", d, 32'h0000_00A5);
  endtask

  task automatic t_tx_count();
    logic [31:0] d;
    do_reset();
    pulse(4'b0001, 7);
    read(8'h08, d); check("R1 tx count", d, 7);
    pulse(4'b0001, 3);
    check("R9 rdata held without read", rdata, 7);
    read(8'h08, d); check("R1 tx count again", d, 10);
  endtask

  task automatic t_rx_snapshot();
    logic [31:0] d;
    do_reset();
    pulse(4'b0011, 3);
    pulse(4'b0010, 2);
    read(8'h0C, d); check("R10 rx before snapshot", d, 0);
    read(8'h08, d); check("R1 tx independent", d, 3);
    read(8'h0C, d); check("R2 rx count via snapshot", d, 5);
    pulse(4'b0010, 4);
    read(8'h0C, d); check("R10 snapshot frozen", d, 5);
    read(8'h08, d);
    read(8'h0C, d); check("R2 rx after new snapshot", d, 9);
  endtask

  task automatic t_stall_underrun();
    logic [31:0] d;
    do_reset();
    pulse(4'b0100, 6);
    pulse(4'b1100, 2);
    read(8'h08, d); check("R1 tx untouched by stall/underrun", d, 0);
    read(8'h10, d); check("R3 stall count", d, 8);
    read(8'h14, d); check("R4 underrun count", d, 2);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    do_reset();
    pulse(4'b0101, CMAX + 5);
    read(8'h08, d); check("R5 tx saturates", d, CMAX);
    read(8'h10, d); check("R5 stall saturates", d, CMAX);
    pulse(4'b0001, 40);
    read(8'h08, d); check("R5 tx no wrap", d, CMAX);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    do_reset();
    pulse(4'b1111, 4);
    read(8'h08, d);
    write_ctrl(32'h0000_0002, 4'b0000);
    read(8'h08, d); check("R6 bit0 clear write no effect", d, 4);
    read(8'h14, d); check("R6 underrun kept", d, 4);
    write_ctrl(32'h0000_0001, 4'b1111);
    read(8'h10, d); check("R6 snapshot zeroed", d, 0);
    read(8'h08, d); check("R6 tx zero, same-cycle event dropped", d, 0);
    read(8'h0C, d); check("R6 rx zero, same-cycle event dropped", d, 0);
    pulse(4'b0001, 2);
    read(8'h08, d); check("R6 counts resume after clear", d, 2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    pulse(4'b0001, 5);
    read(8'h08, d);
    read(8'h00, d); check("R8 ctrl reads zero", d, 0);
    read(8'h18, d); check("R8 unmapped 0x18", d, 0);
    read(8'hFC, d); check("R8 unmapped 0xFC", d, 0);
    read(8'h09, d); check("R8 misaligned 0x09", d, 0);
  endtask

  task automatic t_fatal();
    logic [31:0] d;
    do_reset();
    @(negedge clk); fatal = 1'b1;
    @(negedge clk); fatal = 1'b0;
    read(8'h04, d); check("R7 status fault", d, 0);
    write_ctrl(32'h0000_0001, 4'b0000);
    repeat (3) @(negedge clk);
    read(8'h04, d); check("R7 fault sticky through clear", d, 0);
    do_reset();
    read(8'h04, d); check("R7 healthy after reset", d, 32'h0000_00A5);
  endtask

  initial begin
    t_reset_state();
    t_tx_count();
    t_rx_snapshot();
    t_stall_underrun();
    t_saturate();
    t_clear();
    t_unmapped();
    t_fatal();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule